// File: doc/BRIEF.md
# Four-Channel Power-State Controller

The block decides, for each of four voice channels, whether the channel is powered up or held in power-down, and drives that channel's enable, reset and output-enable toward the framer and datapath. Every channel starts in power-down. A channel powers up only when its power-down request pin has been low long enough, the master clock is running, the rate detector reports lock, and a frame sync then arrives. It returns to power-down on a qualified power-down request, on a run of missing frame syncs, or when the master clock stops.

Request pins, frame syncs and the lock flag are synchronous to the master clock. A separate free-running reference clock watches the master clock. When the master clock stops, the master-clock logic can no longer act. In that case the reference domain forces every channel's outputs to the power-down values, and it holds them there until the master-clock domain has seen the loss and cleared its channel state.

Top module: `chan_pwr_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, every channel is powered down: `active_o` = 0, `oe_o` = 0 and `chan_rst_o` = 1 for every bit. Bit i of every per-channel vector belongs to channel i.
- R2: A powered-up channel whose `pdn_i` bit (1 = power-down request) is sampled high on PDN_QUAL consecutive `clk_i` rising edges drops out on the next edge, so `active_o` falls after edge PDN_QUAL+1. A high run shorter than PDN_QUAL has no effect.
- R3: A powered-down channel powers up after an edge at which its `fs_i` bit is high and `pdn_i` is low, provided `pdn_i` was low on the PDN_QUAL edges before it. A frame sync on the PDN_QUAL-th low edge or earlier does not power it up.
- R4: A window is counted as missing when no `fs_i` pulse arrives for FRAME_CYC + FRAME_CYC/2 edges. The channel powers down one edge after the end of its (MISS_MAX+1)-th consecutive missing window. Any pulse clears the count, so MISS_MAX consecutive misses are tolerated.
- R5: When `clk_i` stops toggling for LOSS_CYC `ref_clk_i` cycles, every channel at once shows `active_o` = 0, `oe_o` = 0 and `chan_rst_o` = 1. After the clock returns, each channel stays down until it meets R3 again with a fresh low run.
- R6: No channel powers up while `lock_i` is low. Dropping `lock_i` forces `active_o` and `oe_o` low but does not assert `chan_rst_o` and does not lose the powered-up state.
- R7: `oe_o` equals `active_o`. `chan_rst_o` is high exactly when the channel is powered down or the clock is lost. Events on one channel do not change another channel's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock; all per-channel logic |
| ref_clk_i | input | 1 | Free-running reference clock for the clock-loss watchdog |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| pdn_i | input | N_CH | Per-channel power-down request, 1 = request |
| fs_i | input | N_CH | Per-channel frame-sync pulse |
| lock_i | input | 1 | Rate detector lock flag |
| active_o | output | N_CH | Channel powered up and usable |
| chan_rst_o | output | N_CH | Channel state reset toward framer and datapath |
| oe_o | output | N_CH | Channel serial data output enable |

## Verification
The bench sweeps high request runs from 1 to PDN_QUAL edges. A design that counted one edge short or did not restart the count on a low sample would drop a channel too early. It places a frame sync exactly on the last qualifying low edge and then one edge later, which catches an off-by-one that powers up before the full low run. It holds frame syncs off for just under and just over the tolerated number of windows, so a wrong window length or miss threshold shows as a missing or a premature drop at an exact edge. It also stops the master clock: a watchdog that does not force the outputs, or a loss flag that clears before the master domain has reset its channels, leaves channels active without a clock or brings them back without requalification.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  typedef enum logic {CH_DOWN = 1'b0, CH_UP = 1'b1} ch_state_e;

  // frame-sync silence tolerated before a window counts as missing
  function automatic int unsigned fs_window(input int unsigned frame_cyc);
    return frame_cyc + frame_cyc / 2;
  endfunction
endpackage

// File: rtl/pdc_run_cnt.sv
module pdc_run_cnt #(
  parameter int unsigned LIMIT = 16,
  parameter bit          LEVEL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic lvl_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (clr_i || (lvl_i != LEVEL)) cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT))       cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == CW'(LIMIT));

  // R2/R3: qualification completes only on a sample at the watched level
  a_r2_run_on_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> ($past(lvl_i) == LEVEL));
endmodule

// File: rtl/pdc_fs_watch.sv
module pdc_fs_watch #(
  parameter int unsigned FRAME_CYC = 1024,
  parameter int unsigned MISS_MAX  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fs_i,
  output logic starved_o
);
  localparam int unsigned WIN = pdc_pkg::fs_window(FRAME_CYC);
  localparam int unsigned GW  = $clog2(WIN);
  localparam int unsigned MW  = $clog2(MISS_MAX + 2);

  logic [GW-1:0] gap_q;
  logic [MW-1:0] miss_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      miss_q <= '0;
    end else if (fs_i) begin
      gap_q  <= '0;
      miss_q <= '0;
    end else if (gap_q == GW'(WIN - 1)) begin
      gap_q <= '0;
      if (miss_q != MW'(MISS_MAX + 1)) miss_q <= miss_q + 1'b1;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign starved_o = (miss_q > MW'(MISS_MAX));

  // R4: a miss is only scored at the end of a full window
  a_r4_miss_at_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((miss_q != $past(miss_q)) && (miss_q != '0)) |-> ($past(gap_q) == GW'(WIN - 1)));
endmodule

// File: rtl/pdc_clk_watch.sv
module pdc_clk_watch #(
  parameter int unsigned LOSS_CYC = 1200
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic tog_i,
  input  logic ack_i,
  output logic lost_o
);
  localparam int unsigned LW = $clog2(LOSS_CYC);

  logic [2:0]    tog_sync_q;
  logic [1:0]    ack_sync_q;
  logic [LW-1:0] cnt_q;
  logic          lost_q;
  logic          mclk_edge;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tog_sync_q <= '0;
      ack_sync_q <= '0;
    end else begin
      tog_sync_q <= {tog_sync_q[1:0], tog_i};
      ack_sync_q <= {ack_sync_q[0], ack_i};
    end
  end

  assign mclk_edge = tog_sync_q[2] ^ tog_sync_q[1];

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)                        cnt_q <= '0;
    else if (mclk_edge)                 cnt_q <= '0;
    else if (cnt_q != LW'(LOSS_CYC - 1)) cnt_q <= cnt_q + 1'b1;
  end

  // loss is held until the master domain has seen it (ack) and edges are back
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni)                                        lost_q <= 1'b0;
    else if (mclk_edge && ack_sync_q[1])                lost_q <= 1'b0;
    else if (!mclk_edge && cnt_q == LW'(LOSS_CYC - 1))  lost_q <= 1'b1;
  end

  assign lost_o = lost_q;

  a_r5_loss_after_timeout: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $rose(lost_q) |-> ($past(cnt_q) == LW'(LOSS_CYC - 1)));
  a_r5_release_needs_ack: assert property (@(posedge ref_clk_i) disable iff (!rst_ni)
    $fell(lost_q) |-> $past(ack_sync_q[1]));
endmodule

// File: rtl/pdc_chan.sv
module pdc_chan #(
  parameter int unsigned PDN_QUAL  = 16,
  parameter int unsigned FRAME_CYC = 1024,
  parameter int unsigned MISS_MAX  = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pdn_i,
  input  logic fs_i,
  input  logic lock_i,
  input  logic lost_i,
  output logic up_o
);
  import pdc_pkg::*;

  logic      pdn_hi_done;
  logic      pdn_lo_done;
  logic      starved;
  ch_state_e state_q, state_d;

  pdc_run_cnt #(.LIMIT(PDN_QUAL), .LEVEL(1'b1)) u_hi_run (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(1'b0), .lvl_i(pdn_i), .done_o(pdn_hi_done)
  );

  // a clock loss forces a fresh low run before recovery
  pdc_run_cnt #(.LIMIT(PDN_QUAL), .LEVEL(1'b0)) u_lo_run (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(lost_i), .lvl_i(pdn_i), .done_o(pdn_lo_done)
  );

  pdc_fs_watch #(.FRAME_CYC(FRAME_CYC), .MISS_MAX(MISS_MAX)) u_fs_watch (
    .clk_i(clk_i), .rst_ni(rst_ni), .fs_i(fs_i), .starved_o(starved)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CH_DOWN: if (pdn_lo_done && !pdn_i && fs_i && lock_i && !lost_i) state_d = CH_UP;
      CH_UP:   if (pdn_hi_done || starved || lost_i)                   state_d = CH_DOWN;
      default: state_d = CH_DOWN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CH_DOWN;
    else         state_q <= state_d;
  end

  assign up_o = (state_q == CH_UP);

  a_r3_up_on_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> $past(fs_i));
  a_r6_up_needs_lock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(up_o) |-> $past(lock_i));
  a_r2_drop_on_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && pdn_hi_done) |=> !up_o);
  a_r4_drop_on_starve: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_o && starved) |=> !up_o);
endmodule

// File: rtl/chan_pwr_ctrl.sv
module chan_pwr_ctrl #(
  parameter int unsigned N_CH      = 4,
  parameter int unsigned PDN_QUAL  = 16,
  parameter int unsigned FRAME_CYC = 1024,
  parameter int unsigned MISS_MAX  = 4,
  parameter int unsigned LOSS_CYC  = 1200
) (
  input  logic            clk_i,
  input  logic            ref_clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] pdn_i,
  input  logic [N_CH-1:0] fs_i,
  input  logic            lock_i,
  output logic [N_CH-1:0] active_o,
  output logic [N_CH-1:0] chan_rst_o,
  output logic [N_CH-1:0] oe_o
);
  logic            tog_q;
  logic [1:0]      lost_sync_q;
  logic            lost_m;
  logic            lost_r;
  logic [N_CH-1:0] up;

  // heartbeat seen by the reference-domain watchdog
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lost_sync_q <= '0;
    else         lost_sync_q <= {lost_sync_q[0], lost_r};
  end

  assign lost_m = lost_sync_q[1];

  pdc_clk_watch #(.LOSS_CYC(LOSS_CYC)) u_clk_watch (
    .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .tog_i(tog_q), .ack_i(lost_m), .lost_o(lost_r)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    pdc_chan #(
      .PDN_QUAL (PDN_QUAL),
      .FRAME_CYC(FRAME_CYC),
      .MISS_MAX (MISS_MAX)
    ) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pdn_i (pdn_i[g]),
      .fs_i  (fs_i[g]),
      .lock_i(lock_i),
      .lost_i(lost_m),
      .up_o  (up[g])
    );

    // outputs fall at once from the reference domain when the clock is gone
    assign active_o[g]   = up[g] & lock_i & ~lost_r;
    assign oe_o[g]       = active_o[g];
    assign chan_rst_o[g] = ~up[g] | lost_r;

    a_r5_loss_clears_chan: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lost_m |=> !up[g]);
  end
endmodule

// File: tb/chan_pwr_ctrl_tb.sv
`timescale 1ns/1ps
module chan_pwr_ctrl_tb;
  localparam int unsigned N        = 4;
  localparam int unsigned QUAL     = 16;
  localparam int unsigned FRAME    = 8;
  localparam int unsigned MISSMAX  = 4;
  localparam int unsigned LOSS     = 24;
  localparam int unsigned WIN      = FRAME + FRAME / 2;

  logic         clk_i = 1'b0;
  logic         ref_clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] pdn_i = '0;
  logic [N-1:0] fs_i = '0;
  logic         lock_i = 1'b0;
  logic [N-1:0] active_o, chan_rst_o, oe_o;

  logic         clk_run = 1'b1;
  logic [N-1:0] fs_en = '0;
  logic [N-1:0] fs_force = '0;
  int unsigned  per_cnt = 0;
  int           n_tests = 0;
  int           n_fail = 0;

  chan_pwr_ctrl #(
    .N_CH(N), .PDN_QUAL(QUAL), .FRAME_CYC(FRAME), .MISS_MAX(MISSMAX), .LOSS_CYC(LOSS)
  ) u_dut (
    .clk_i(clk_i), .ref_clk_i(ref_clk_i), .rst_ni(rst_ni), .pdn_i(pdn_i), .fs_i(fs_i),
    .lock_i(lock_i), .active_o(active_o), .chan_rst_o(chan_rst_o), .oe_o(oe_o)
  );

  always begin
    #2.5;
    if (clk_run) clk_i = ~clk_i;
  end
  always #1.5 ref_clk_i = ~ref_clk_i;

  task automatic chk(input string req, input string what, input logic [N-1:0] act,
                     input logic [N-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // one master edge with periodic and forced frame syncs; returns at the next negedge
  task automatic tick();
    fs_i = ((per_cnt == 0) ? fs_en : '0) | fs_force;
    @(negedge clk_i);
    fs_force = '0;
    per_cnt  = (per_cnt == FRAME - 1) ? 0 : per_cnt + 1;
  endtask

  initial begin
    #1ms;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic ok;
    pdn_i = 4'b1000;
    repeat (3) @(negedge clk_i);
    chk("R1", "active in reset", active_o, 4'b0000);
    chk("R1", "reset in reset", chan_rst_o, 4'b1111);
    chk("R1", "oe in reset", oe_o, 4'b0000);
    rst_ni = 1'b1;
    repeat (3) tick();
    chk("R1", "active after release", active_o, 4'b0000);

    // R6: low run and frame syncs but no lock
    fs_en = 4'b1111;
    repeat (40) tick();
    chk("R6", "no power-up without lock", active_o, 4'b0000);
    chk("R6", "reset without lock", chan_rst_o, 4'b1111);

    // R3: exact qualification edge
    lock_i = 1'b1;
    fs_en  = '0;
    pdn_i  = 4'b1111;
    tick();
    pdn_i = 4'b1000;
    repeat (QUAL - 1) tick();
    fs_force = 4'b0001;
    tick();
    chk("R3", "fs on last qualifying edge", active_o, 4'b0000);
    fs_force = 4'b0010;
    tick();
    chk("R3", "fs one edge later", active_o, 4'b0010);
    fs_force = 4'b1101;
    tick();
    chk("R3", "ch3 held by request", active_o, 4'b0111);
    chk("R7", "reset vector", chan_rst_o, 4'b1000);
    chk("R7", "oe follows active", oe_o, 4'b0111);
    fs_en = 4'b1111;

    // R6: lock drop gates without reset
    lock_i = 1'b0;
    #1;
    chk("R6", "active gated by lock", active_o, 4'b0000);
    chk("R6", "lock drop no reset", chan_rst_o, 4'b1000);
    lock_i = 1'b1;
    #1;
    chk("R6", "state kept over lock drop", active_o, 4'b0111);

    // R2: high runs shorter than qualification
    for (int l = 1; l < QUAL; l++) begin
      ok = 1'b1;
      pdn_i[1] = 1'b1;
      repeat (l) begin
        tick();
        if (active_o[1] !== 1'b1) ok = 1'b0;
      end
      pdn_i[1] = 1'b0;
      repeat (2) begin
        tick();
        if (active_o[1] !== 1'b1) ok = 1'b0;
      end
      chk("R2", $sformatf("short run %0d", l), {3'b000, ok}, 4'b0001);
    end
    pdn_i[1] = 1'b1;
    repeat (QUAL) tick();
    chk("R2", "still up after full run", active_o, 4'b0111);
    tick();
    chk("R2", "down one edge after full run", active_o, 4'b0101);
    chk("R7", "only ch1 reset", chan_rst_o, 4'b1010);

    // R3: recovery of ch1
    pdn_i[1] = 1'b0;
    fs_en[1] = 1'b0;
    repeat (QUAL) tick();
    chk("R3", "down before recovery sync", active_o, 4'b0101);
    fs_force = 4'b0010;
    tick();
    chk("R3", "recovered on sync", active_o, 4'b0111);
    fs_en[1] = 1'b1;

    // R4: missing frame syncs on ch2
    fs_en[2] = 1'b0;
    fs_force = 4'b0100;
    tick();
    ok = 1'b1;
    repeat (MISSMAX * WIN + WIN / 2) begin
      tick();
      if (active_o[2] !== 1'b1) ok = 1'b0;
    end
    chk("R4", "tolerated misses", {3'b000, ok}, 4'b0001);
    fs_force = 4'b0100;
    tick();
    repeat ((MISSMAX + 1) * WIN) tick();
    chk("R4", "up at last window end", active_o, 4'b0111);
    tick();
    chk("R4", "down after extra miss", active_o, 4'b0011);
    chk("R4", "ch2 reset", chan_rst_o, 4'b1100);
    fs_en[2] = 1'b1;
    repeat (FRAME + 2) tick();
    chk("R3", "ch2 back on next sync", active_o, 4'b0111);

    // R5: master clock loss
    clk_run = 1'b0;
    #30;
    chk("R5", "not lost before timeout", active_o, 4'b0111);
    #150;
    chk("R5", "active forced low", active_o, 4'b0000);
    chk("R5", "reset forced high", chan_rst_o, 4'b1111);
    chk("R5", "oe forced low", oe_o, 4'b0000);
    clk_run = 1'b1;
    @(negedge clk_i);
    repeat (10) tick();
    chk("R5", "down after clock return", active_o, 4'b0000);
    repeat (40) tick();
    chk("R5", "requalified after return", active_o, 4'b0111);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule